// File: doc/BRIEF.md
# Translation and Access-Fault Checker

This block sits after the translation lookaside buffer in a load/store or fetch pipeline. Each request carries a virtual address, an access size, the requester's privilege and hypervisor state, an address-mask mode and the result of the TLB lookup made for that address. The block decides whether the access may proceed. If it may, the block returns the physical address. If it may not, it returns a fault code, a packed status word that describes the fault and, for data accesses, the faulting address.

The checks run in a fixed priority and only the first fault found is reported. Pages vary in size from entry to entry, so the physical address combines the page frame from the TLB with the low virtual-address bits that fall inside the page. Hypervisor and red state skip translation completely. All results are registered and appear one cycle after the request, qualified by a valid strobe.

Top module: `xlt_fault_chk`

## Requirements
- R1: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. While `rsp_valid_o` is low, every other output is zero, and all outputs are zero after reset.
- R2: With size code s (access of 2^s bytes, s = 0..3), the access is misaligned when the low s bits of `req_va_i` are not all zero. This gives fault code 1, with status write bit 0 and side-effect bit 0.
- R3: When `req_amask_i` is high, the address is cut to its low 32 bits (upper bits read as zero) before the range check, the bypass address, the page-offset merge and the fault address of non-alignment faults.
- R4: After masking, an address whose bits 47..43 are neither all zero nor all one gives fault code 2, with status side-effect bit 1 and write bit 0.
- R5: When `req_hpriv_i` or `req_red_i` is high and neither R2 nor R4 applies, there is no fault and the TLB inputs have no effect. `rsp_pa_o` is the masked address's low 40 bits.
- R6: Otherwise a TLB miss (`tlb_hit_i` low) gives fault code 3, with write bit equal to `req_write_i` and side-effect bit 0.
- R7: Otherwise a hit with `tlb_priv_i` high and `req_priv_i` low gives fault code 4, with write bit equal to `req_write_i` and side-effect bit equal to `tlb_side_eff_i`. A privileged requester gets no fault from such a page.
- R8: Page size code p (0..3) gives an offset of 13+3p bits (8 KiB, 64 KiB, 512 KiB, 4 MiB). On success without bypass, `rsp_pa_o` takes the offset bits from the masked address and the remaining bits from `tlb_pa_i`.
- R9: The priority is alignment, then range, then bypass, then miss, then privilege. A fault returns `rsp_pa_o` = 0.
- R10: Status word layout: bit 2 write, bits 5:4 `req_ctx_type_i`, bit 6 side-effect, bits 9:7 fault code, bits 23:16 `req_asi_i`, and every other bit 0. The whole word is zero when there is no fault.
- R11: A fault with `req_data_i` high sets `rsp_far_valid_o` and `rsp_far_o`. `rsp_far_o` holds the raw address for an alignment fault and the masked address for any other fault. Instruction-side faults and successes leave both at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_va_i | input | 48 | Virtual address |
| req_size_i | input | 2 | Log2 of access size in bytes |
| req_write_i | input | 1 | Store access |
| req_data_i | input | 1 | Data-side request (0 = instruction fetch) |
| req_priv_i | input | 1 | Privileged requester |
| req_hpriv_i | input | 1 | Hypervisor state |
| req_red_i | input | 1 | Red state |
| req_amask_i | input | 1 | 32-bit address-mask mode |
| req_ctx_type_i | input | 2 | Context type, copied to status word |
| req_asi_i | input | 8 | Address space identifier, copied to status word |
| tlb_hit_i | input | 1 | TLB lookup hit |
| tlb_pa_i | input | 40 | Page frame address from the entry |
| tlb_pg_sz_i | input | 2 | Page size code of the entry |
| tlb_priv_i | input | 1 | Entry is a privileged page |
| tlb_side_eff_i | input | 1 | Entry has side effects |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_fault_o | output | 1 | Access faulted |
| rsp_fault_code_o | output | 3 | Fault code (0 none) |
| rsp_pa_o | output | 40 | Physical address |
| rsp_fsr_o | output | 24 | Packed fault status word |
| rsp_far_o | output | 48 | Fault address (data side) |
| rsp_far_valid_o | output | 1 | Fault address is valid |

## Verification
On every cycle the assertions check the following: the one-cycle response timing, the quiet outputs between responses, the agreement between the code field in the status word and the fault code, the zero status word on success, the side-effect bit on range faults, the preserved low page-offset bits, the absence of miss and privilege faults under bypass, and the rule that only data-side faults report an address. The bench alone covers the rest: the exact merged address for each page size, the effect of address masking on range and fault address, and which fault wins when several conditions hold together. It checks these against a reference model on directed corner cases and randomized requests.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_RANGE = 3'd2,
    FLT_MISS  = 3'd3,
    FLT_PRIV  = 3'd4
  } flt_e;

  localparam int FSR_W       = 24;
  localparam int FSR_WR_BIT  = 2;
  localparam int FSR_CTX_LSB = 4;
  localparam int FSR_SE_BIT  = 6;
  localparam int FSR_FT_LSB  = 7;
  localparam int FSR_ASI_LSB = 16;
endpackage

// File: rtl/xlt_va_check.sv
module xlt_va_check #(
  parameter int VA_W    = 48,
  parameter int VALID_W = 44,
  parameter int AMASK_W = 32,
  parameter int SIZE_W  = 2
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              amask_i,
  output logic              misalign_o,
  output logic [VA_W-1:0]   va_eff_o,
  output logic              range_err_o
);
  localparam int LOW_W = 1 << SIZE_W;
  localparam int HI_W  = VA_W - VALID_W + 1;

  logic [LOW_W-1:0] low_mask;
  logic [VA_W-1:0]  amask_vec;
  logic [HI_W-1:0]  hi_bits;

  assign low_mask   = (LOW_W'(1) << size_i) - LOW_W'(1);
  assign misalign_o = |(va_i[LOW_W-1:0] & low_mask);

  assign amask_vec = amask_i ? {{(VA_W-AMASK_W){1'b0}}, {AMASK_W{1'b1}}} : {VA_W{1'b1}};
  assign va_eff_o  = va_i & amask_vec;

  // canonical when the upper bits are a sign extension of bit VALID_W-1
  assign hi_bits     = va_eff_o[VA_W-1:VALID_W-1];
  assign range_err_o = !((&hi_bits) || !(|hi_bits));
endmodule

// File: rtl/xlt_pa_merge.sv
module xlt_pa_merge #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 40,
  parameter int NUM_PG   = 4,
  parameter int PG_BASE  = 13,
  parameter int PG_STEP  = 3,
  parameter int PGSZ_W   = $clog2(NUM_PG)
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [PA_W-1:0]   frame_i,
  input  logic [PGSZ_W-1:0] pg_sz_i,
  output logic [PA_W-1:0]   pa_o
);
  logic [PA_W-1:0] pg_mask [NUM_PG];
  logic [PA_W-1:0] off_mask;

  for (genvar g = 0; g < NUM_PG; g++) begin : g_mask
    localparam int SH = PG_BASE + g * PG_STEP;
    assign pg_mask[g] = PA_W'((64'd1 << SH) - 64'd1);
  end

  assign off_mask = pg_mask[pg_sz_i];
  assign pa_o     = (frame_i & ~off_mask) | (va_i[PA_W-1:0] & off_mask);
endmodule

// File: rtl/xlt_fsr_pack.sv
module xlt_fsr_pack
  import xlt_pkg::*;
#(
  parameter int ASI_W = 8
) (
  input  logic             write_i,
  input  logic [1:0]       ctx_i,
  input  logic             se_i,
  input  flt_e             code_i,
  input  logic [ASI_W-1:0] asi_i,
  output logic [FSR_W-1:0] fsr_o
);
  always_comb begin
    fsr_o = '0;
    if (code_i != FLT_NONE) begin
      fsr_o[FSR_WR_BIT]                  = write_i;
      fsr_o[FSR_CTX_LSB +: 2]            = ctx_i;
      fsr_o[FSR_SE_BIT]                  = se_i;
      fsr_o[FSR_FT_LSB +: 3]             = code_i;
      fsr_o[FSR_ASI_LSB +: ASI_W]        = asi_i;
    end
  end
endmodule

// File: rtl/xlt_fault_chk.sv
module xlt_fault_chk
  import xlt_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int VALID_W = 44,
  parameter int AMASK_W = 32,
  parameter int NUM_PG  = 4,
  parameter int PG_BASE = 13,
  parameter int PG_STEP = 3,
  parameter int ASI_W   = 8,
  parameter int SIZE_W  = 2,
  parameter int PGSZ_W  = $clog2(NUM_PG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_write_i,
  input  logic              req_data_i,
  input  logic              req_priv_i,
  input  logic              req_hpriv_i,
  input  logic              req_red_i,
  input  logic              req_amask_i,
  input  logic [1:0]        req_ctx_type_i,
  input  logic [ASI_W-1:0]  req_asi_i,
  input  logic              tlb_hit_i,
  input  logic [PA_W-1:0]   tlb_pa_i,
  input  logic [PGSZ_W-1:0] tlb_pg_sz_i,
  input  logic              tlb_priv_i,
  input  logic              tlb_side_eff_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [2:0]        rsp_fault_code_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [FSR_W-1:0]  rsp_fsr_o,
  output logic [VA_W-1:0]   rsp_far_o,
  output logic              rsp_far_valid_o
);
  logic            misalign, range_err;
  logic [VA_W-1:0] va_eff;
  logic [PA_W-1:0] pa_merged;
  logic [FSR_W-1:0] fsr_d;

  flt_e            code_d;
  logic            se_d, wr_d, fault_d, far_v_d;
  logic [PA_W-1:0] pa_d;
  logic [VA_W-1:0] far_d;

  xlt_va_check #(
    .VA_W(VA_W), .VALID_W(VALID_W), .AMASK_W(AMASK_W), .SIZE_W(SIZE_W)
  ) u_va_check (
    .va_i       (req_va_i),
    .size_i     (req_size_i),
    .amask_i    (req_amask_i),
    .misalign_o (misalign),
    .va_eff_o   (va_eff),
    .range_err_o(range_err)
  );

  xlt_pa_merge #(
    .VA_W(VA_W), .PA_W(PA_W), .NUM_PG(NUM_PG),
    .PG_BASE(PG_BASE), .PG_STEP(PG_STEP), .PGSZ_W(PGSZ_W)
  ) u_pa_merge (
    .va_i   (va_eff),
    .frame_i(tlb_pa_i),
    .pg_sz_i(tlb_pg_sz_i),
    .pa_o   (pa_merged)
  );

  // fixed priority: align > range > bypass > miss > priv
  always_comb begin
    code_d = FLT_NONE;
    se_d   = 1'b0;
    wr_d   = 1'b0;
    pa_d   = pa_merged;
    far_d  = va_eff;
    if (misalign) begin
      code_d = FLT_ALIGN;
      far_d  = req_va_i;
    end else if (range_err) begin
      code_d = FLT_RANGE;
      se_d   = 1'b1;
    end else if (req_hpriv_i || req_red_i) begin
      pa_d = va_eff[PA_W-1:0];
    end else if (!tlb_hit_i) begin
      code_d = FLT_MISS;
      wr_d   = req_write_i;
    end else if (!req_priv_i && tlb_priv_i) begin
      code_d = FLT_PRIV;
      wr_d   = req_write_i;
      se_d   = tlb_side_eff_i;
    end
    fault_d = (code_d != FLT_NONE);
    far_v_d = fault_d && req_data_i;
  end

  xlt_fsr_pack #(.ASI_W(ASI_W)) u_fsr_pack (
    .write_i(wr_d),
    .ctx_i  (req_ctx_type_i),
    .se_i   (se_d),
    .code_i (code_d),
    .asi_i  (req_asi_i),
    .fsr_o  (fsr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o      <= 1'b0;
      rsp_fault_o      <= 1'b0;
      rsp_fault_code_o <= '0;
      rsp_pa_o         <= '0;
      rsp_fsr_o        <= '0;
      rsp_far_o        <= '0;
      rsp_far_valid_o  <= 1'b0;
    end else begin
      rsp_valid_o      <= req_valid_i;
      rsp_fault_o      <= req_valid_i && fault_d;
      rsp_fault_code_o <= req_valid_i ? code_d : FLT_NONE;
      rsp_pa_o         <= (req_valid_i && !fault_d) ? pa_d : '0;
      rsp_fsr_o        <= req_valid_i ? fsr_d : '0;
      rsp_far_o        <= (req_valid_i && far_v_d) ? far_d : '0;
      rsp_far_valid_o  <= req_valid_i && far_v_d;
    end
  end
endmodule

// File: rtl/xlt_fault_chk_sva.sv
module xlt_fault_chk_sva #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int PG_BASE = 13,
  parameter int SIZE_W  = 2,
  parameter int FSR_W   = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [VA_W-1:0]   req_va_i,
  input logic [SIZE_W-1:0] req_size_i,
  input logic              req_data_i,
  input logic              req_hpriv_i,
  input logic              req_red_i,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [2:0]        rsp_fault_code_o,
  input logic [PA_W-1:0]   rsp_pa_o,
  input logic [FSR_W-1:0]  rsp_fsr_o,
  input logic              rsp_far_valid_o
);
  localparam int LOW_W = 1 << SIZE_W;

  logic req_misalign;
  assign req_misalign = |(req_va_i[LOW_W-1:0] & ((LOW_W'(1) << req_size_i) - LOW_W'(1)));

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R1
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_fault_o && !rsp_far_valid_o && rsp_fsr_o == '0)); // R1
  AST_MISALIGN_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_misalign) |=> (rsp_fault_code_o == 3'd1)); // R2
  AST_RANGE_SE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_code_o == 3'd2) |-> (rsp_fsr_o[6] && !rsp_fsr_o[2])); // R4
  AST_BYPASS_NO_TLB_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_hpriv_i || req_red_i)) |=>
      (rsp_fault_code_o != 3'd3 && rsp_fault_code_o != 3'd4)); // R5
  AST_PA_LOW_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_pa_o[PG_BASE-1:0] == $past(req_va_i[PG_BASE-1:0]))); // R8
  AST_OK_FSR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_fsr_o == '0 && rsp_fault_code_o == 3'd0)); // R10
  AST_FSR_CODE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fsr_o[9:7] == rsp_fault_code_o)); // R10
  AST_FAR_DATA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_far_valid_o |-> (rsp_fault_o && $past(req_data_i))); // R11
endmodule

bind xlt_fault_chk xlt_fault_chk_sva #(
  .VA_W(VA_W), .PA_W(PA_W), .PG_BASE(PG_BASE), .SIZE_W(SIZE_W), .FSR_W(xlt_pkg::FSR_W)
) u_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_va_i        (req_va_i),
  .req_size_i      (req_size_i),
  .req_data_i      (req_data_i),
  .req_hpriv_i     (req_hpriv_i),
  .req_red_i       (req_red_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_fault_code_o(rsp_fault_code_o),
  .rsp_pa_o        (rsp_pa_o),
  .rsp_fsr_o       (rsp_fsr_o),
  .rsp_far_valid_o (rsp_far_valid_o)
);

// File: tb/tb_xlt_fault_chk.sv
module tb_xlt_fault_chk;
  localparam time CLK_P = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [47:0] req_va_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_data_i = 1'b0;
  logic        req_priv_i = 1'b0;
  logic        req_hpriv_i = 1'b0;
  logic        req_red_i = 1'b0;
  logic        req_amask_i = 1'b0;
  logic [1:0]  req_ctx_type_i = '0;
  logic [7:0]  req_asi_i = '0;
  logic        tlb_hit_i = 1'b0;
  logic [39:0] tlb_pa_i = '0;
  logic [1:0]  tlb_pg_sz_i = '0;
  logic        tlb_priv_i = 1'b0;
  logic        tlb_side_eff_i = 1'b0;

  logic        rsp_valid_o, rsp_fault_o, rsp_far_valid_o;
  logic [2:0]  rsp_fault_code_o;
  logic [39:0] rsp_pa_o;
  logic [23:0] rsp_fsr_o;
  logic [47:0] rsp_far_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  xlt_fault_chk dut (.*);

  typedef struct {
    logic        fault;
    logic [2:0]  code;
    logic [39:0] pa;
    logic [23:0] fsr;
    logic [47:0] far;
    logic        far_v;
  } exp_t;

  function automatic exp_t model();
    exp_t e;
    logic [47:0] va_e;
    logic        mis, rng, se, wr;
    logic [4:0]  hi;
    logic [39:0] om;
    va_e = req_amask_i ? {16'h0, req_va_i[31:0]} : req_va_i;
    mis  = (req_va_i[3:0] & ((4'd1 << req_size_i) - 4'd1)) != 4'd0;
    hi   = va_e[47:43];
    rng  = !(hi == 5'h00 || hi == 5'h1f);
    om   = 40'((64'd1 << (13 + 3 * int'(tlb_pg_sz_i))) - 64'd1);
    e.code = 3'd0; se = 1'b0; wr = 1'b0;
    e.pa = (tlb_pa_i & ~om) | (va_e[39:0] & om);
    if (mis) e.code = 3'd1;
    else if (rng) begin e.code = 3'd2; se = 1'b1; end
    else if (req_hpriv_i || req_red_i) e.pa = va_e[39:0];
    else if (!tlb_hit_i) begin e.code = 3'd3; wr = req_write_i; end
    else if (!req_priv_i && tlb_priv_i) begin e.code = 3'd4; wr = req_write_i; se = tlb_side_eff_i; end
    e.fault = (e.code != 3'd0);
    if (e.fault) e.pa = '0;
    e.fsr = e.fault ? {req_asi_i, 6'b0, e.code, se, req_ctx_type_i, 1'b0, wr, 2'b0} : 24'h0;
    e.far_v = e.fault && req_data_i;
    e.far = e.far_v ? (mis ? req_va_i : va_e) : 48'h0;
    return e;
  endfunction

  task automatic chk(string tag, string fld, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  // inputs already set; one clock later the registered response is sampled
  task automatic go(string tag);
    exp_t e;
    e = model();
    req_valid_i = 1'b1;
    @(negedge clk_i);
    chk(tag, "valid", 64'(rsp_valid_o), 64'd1);
    chk(tag, "fault", 64'(rsp_fault_o), 64'(e.fault));
    chk(tag, "code",  64'(rsp_fault_code_o), 64'(e.code));
    chk(tag, "pa",    64'(rsp_pa_o), 64'(e.pa));
    chk(tag, "fsr",   64'(rsp_fsr_o), 64'(e.fsr));
    chk(tag, "far",   64'(rsp_far_o), 64'(e.far));
    chk(tag, "far_v", 64'(rsp_far_valid_o), 64'(e.far_v));
  endtask

  task automatic base();
    req_va_i = 48'h0000_1234_5000; req_size_i = 2'd3; req_write_i = 1'b0;
    req_data_i = 1'b1; req_priv_i = 1'b0; req_hpriv_i = 1'b0; req_red_i = 1'b0;
    req_amask_i = 1'b0; req_ctx_type_i = 2'd1; req_asi_i = 8'h80;
    tlb_hit_i = 1'b1; tlb_pa_i = 40'hAB_CDEF_0123; tlb_pg_sz_i = 2'd0;
    tlb_priv_i = 1'b0; tlb_side_eff_i = 1'b0;
  endtask

  task automatic rand_req();
    logic [47:0] v;
    v = {16'($urandom), $urandom};
    if ($urandom % 8 < 6) v[47:43] = {5{v[43]}};
    if ($urandom % 4 != 0) v[2:0] = 3'b0;
    req_va_i = v;
    req_size_i = 2'($urandom);
    req_write_i = 1'($urandom);
    req_data_i = 1'($urandom);
    req_priv_i = 1'($urandom);
    req_hpriv_i = ($urandom % 8) == 0;
    req_red_i = ($urandom % 16) == 0;
    req_amask_i = ($urandom % 4) == 0;
    req_ctx_type_i = 2'($urandom);
    req_asi_i = 8'($urandom);
    tlb_hit_i = ($urandom % 8) != 0;
    tlb_pa_i = {8'($urandom), $urandom};
    tlb_pg_sz_i = 2'($urandom);
    tlb_priv_i = 1'($urandom);
    tlb_side_eff_i = 1'($urandom);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 reset", "valid", 64'(rsp_valid_o), 64'd0);
    chk("R1 reset", "fsr", 64'(rsp_fsr_o), 64'd0);
    chk("R1 reset", "pa", 64'(rsp_pa_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    base(); go("R8 pg0 merge");
    base(); tlb_pg_sz_i = 2'd3; req_va_i = 48'h0000_7654_3218; go("R8 pg3 merge");
    base(); req_size_i = 2'd2; req_va_i = 48'h4000_0000_0002; go("R2 R9 misalign beats range");
    base(); req_size_i = 2'd1; req_va_i = 48'h0000_0000_0011; req_data_i = 1'b0; go("R2 R11 ifetch misalign");
    base(); req_va_i = 48'h2000_0000_0000; tlb_hit_i = 1'b0; req_write_i = 1'b1; go("R4 R9 range beats miss");
    base(); req_amask_i = 1'b1; req_va_i = 48'h5A5A_8765_4320; tlb_hit_i = 1'b0; go("R3 R11 amask far");
    base(); req_amask_i = 1'b1; req_va_i = 48'h3333_0000_A000; go("R3 amask merge");
    base(); req_hpriv_i = 1'b1; tlb_hit_i = 1'b0; req_va_i = 48'hFFFF_F123_4560; go("R5 hpriv bypass");
    base(); req_red_i = 1'b1; tlb_priv_i = 1'b1; go("R5 red bypass");
    base(); tlb_hit_i = 1'b0; tlb_priv_i = 1'b1; req_write_i = 1'b1; go("R6 R9 miss beats priv");
    base(); tlb_priv_i = 1'b1; tlb_side_eff_i = 1'b1; req_write_i = 1'b1; req_data_i = 1'b0; go("R7 R11 priv violation");
    base(); tlb_priv_i = 1'b1; req_priv_i = 1'b1; go("R7 priv ok");
    base(); tlb_hit_i = 1'b0; req_ctx_type_i = 2'd2; req_asi_i = 8'hA5; go("R10 fsr layout");

    // R1: idle cycle gives no response
    req_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R1 idle", "valid", 64'(rsp_valid_o), 64'd0);
    chk("R1 idle", "fault", 64'(rsp_fault_o), 64'd0);
    chk("R1 idle", "far_v", 64'(rsp_far_valid_o), 64'd0);

    for (int i = 0; i < 400; i++) begin
      rand_req();
      go("R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule